// File: doc/BRIEF.md
# Programmable Memory Map Decoder

This block turns the 16-bit address of an 8-bit CPU into the selects for an on-board RAM, an on-board ROM and the data-bus transceiver to the main board. A fixed decoder would normally do this work. Here a small writable table does it instead. The table has one entry for each 2 KB window of the address space, and the top five address bits pick the entry. A window can therefore be as small as a 2 KB I/O area, and the whole layout of RAM, ROM and I/O can be changed by loading new entries.

A host controller raises a configuration flag and writes the entries before the CPU runs. During a bus cycle the block samples the address and the read/write line when the phase-2 clock rises. It holds the resulting selects for as long as phase 2 stays high. A per-window protect bit blocks CPU writes to that window. The window that holds the main board's video RAM is always routed through the transceiver and never to the on-board RAM.

Top module: `memmap_decoder`

## Requirements
- R1: The entry used for a cycle is the one indexed by addr[15:11]. This gives 32 independent windows of 2 KB each, so neighbouring windows such as 0xE000 and 0xE800 decode on their own.
- R2: An entry is 4 bits wide. Bit 3 selects the on-board RAM, bit 2 selects the on-board ROM, bit 1 enables the transceiver and bit 0 protects the window against writes.
- R3: The address and rw are captured at the first clk edge that sees phi2 high after phi2 was low. The outputs follow from that edge and do not change while phi2 stays high, even if the address changes. At the first clk edge that sees phi2 low, all outputs return to 0.
- R4: In a protected window (bit 0 = 1), a CPU write (rw = 0) produces no ram_wr pulse, while the RAM select is still asserted. A read in the same window is decoded normally.
- R5: A CPU write to an unprotected window with bit 3 set asserts ram_wr together with ram_sel. A write to a ROM-only window never asserts ram_wr.
- R6: xcvr_to_cpu is 1 (board-to-CPU) when the transceiver is enabled and rw = 1. On a write it is 0 (CPU-to-board), and it is always 0 when xcvr_en is 0.
- R7: Any entry written to window VIDEO_IDX (default 16, address 0x8000) is stored with bit 3 cleared and bit 1 set. That window therefore never selects the on-board RAM and always enables the transceiver.
- R8: While cfg_active = 1, all outputs are held at 0. A table write (cfg_we = 1) is accepted only while cfg_active = 1; otherwise it is ignored.
- R9: Synchronous active-low reset clears every table entry and all outputs, so no device is selected until the table has been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | CPU phase-2 clock level |
| addr | input | 16 | CPU address bus |
| rw | input | 1 | CPU read/write line, 1 = read |
| cfg_active | input | 1 | Configuration mode |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 5 | Table entry to write |
| cfg_data | input | 4 | Entry value {ram, rom, xcvr, protect} |
| ram_sel | output | 1 | On-board RAM chip select |
| rom_sel | output | 1 | On-board ROM chip select |
| ram_wr | output | 1 | On-board RAM write strobe |
| xcvr_en | output | 1 | Main-board transceiver enable |
| xcvr_to_cpu | output | 1 | Transceiver direction, 1 = board to CPU |

## Verification
Two functions can fall in the same clk cycle: a phase-2 rising edge, which would capture a decode, and an active configuration window, whose write port must win. The bench provokes this by raising phi2 with a loaded window on the bus while cfg_active is high and a table write is under way. It then judges that every output stays 0 and that the new entry decodes as written on the next ordinary cycle. A second pairing moves the address while phi2 is high, to show that the captured decode holds.

// File: rtl/mmd_pkg.sv
// Package: shared entry layout for the memory map decoder.
// Assumes entries are 4 bits, packed MSB first as {ram, rom, xcvr, protect}.
package mmd_pkg;
    typedef struct packed {
        logic ram;
        logic rom;
        logic xcvr;
        logic protect;
    } map_entry_t;
endpackage

// File: rtl/mmd_phase_edge.sv
// Module: detects the rising edge of the CPU phase-2 clock as seen by clk.
// Assumes phi2 is already synchronous to clk (bench and board drive it so).
module mmd_phase_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    output logic phi2_rise
);
    logic phi2_q;

    // Remember the phase-2 level seen at the previous clk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phi2_q <= 1'b0;
        else        phi2_q <= phi2;
    end

    assign phi2_rise = phi2 & ~phi2_q;

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phi2_rise |=> !phi2_rise);
endmodule

// File: rtl/mmd_map_table.sv
// Module: writable window table with one write port and one read port.
// Assumes writes land only during configuration; the video window is
// forced so that it maps to the main board.
module mmd_map_table
    import mmd_pkg::*;
#(
    parameter int IDX_W     = 5,
    parameter int VIDEO_IDX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_active,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  map_entry_t       cfg_data,
    input  logic [IDX_W-1:0] rd_idx,
    output map_entry_t       rd_entry
);
    localparam int DEPTH = 1 << IDX_W;

    map_entry_t tbl [DEPTH];
    logic       wr_ok;

    assign wr_ok = cfg_active & cfg_we;

    // Clear or load the table; each slot is its own register.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl[g] <= '0;
            end else if (wr_ok && (cfg_idx == IDX_W'(g))) begin
                if (g == VIDEO_IDX) tbl[g] <= '{ram: 1'b0, rom: cfg_data.rom,
                                               xcvr: 1'b1, protect: cfg_data.protect};
                else                tbl[g] <= cfg_data;
            end
        end
    end

    assign rd_entry = tbl[rd_idx];

    // R7
    video_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && cfg_idx == IDX_W'(VIDEO_IDX)) |=> (tbl[VIDEO_IDX].xcvr && !tbl[VIDEO_IDX].ram));
    // R8
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_active && rd_idx == cfg_idx) |=> $stable(tbl[$past(cfg_idx)]));
endmodule

// File: rtl/mmd_cycle_decode.sv
// Module: turns a table entry and rw into registered bus selects.
// Assumes capture happens on the phase-2 rise; outputs are held through
// phase 2 and dropped when phase 2 falls or configuration is active.
module mmd_cycle_decode
    import mmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phi2,
    input  logic       phi2_rise,
    input  logic       cfg_active,
    input  map_entry_t entry,
    input  logic       rw,
    output logic       ram_sel,
    output logic       rom_sel,
    output logic       ram_wr,
    output logic       xcvr_en,
    output logic       xcvr_to_cpu
);
    // Capture the selects at phase-2 rise, hold them, drop them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_active || !phi2) begin
            ram_sel     <= 1'b0;
            rom_sel     <= 1'b0;
            ram_wr      <= 1'b0;
            xcvr_en     <= 1'b0;
            xcvr_to_cpu <= 1'b0;
        end else if (phi2_rise) begin
            ram_sel     <= entry.ram;
            rom_sel     <= entry.rom;
            ram_wr      <= entry.ram & ~rw & ~entry.protect;
            xcvr_en     <= entry.xcvr;
            xcvr_to_cpu <= entry.xcvr & rw;
        end
    end

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(ram_sel | rom_sel | ram_wr | xcvr_en | xcvr_to_cpu));
    // R8
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_active |=> !(ram_sel | rom_sel | ram_wr | xcvr_en));
    // R5
    wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (ram_sel && !xcvr_to_cpu));
    // R6
    dir_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_to_cpu |-> xcvr_en);
    // R3
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && !phi2_rise && !cfg_active) |=> $stable({ram_sel, rom_sel, ram_wr, xcvr_en, xcvr_to_cpu}));
endmodule

// File: rtl/memmap_decoder.sv
// Module: top of the programmable memory map decoder.
// Assumes a host loads the table under cfg_active before the CPU runs.
module memmap_decoder
    import mmd_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int IDX_W     = 5,
    parameter int VIDEO_IDX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              cfg_active,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [3:0]        cfg_data,
    output logic              ram_sel,
    output logic              rom_sel,
    output logic              ram_wr,
    output logic              xcvr_en,
    output logic              xcvr_to_cpu
);
    localparam int IDX_LSB = ADDR_W - IDX_W;

    logic       phi2_rise;
    map_entry_t entry;

    mmd_phase_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .phi2_rise (phi2_rise)
    );

    mmd_map_table #(.IDX_W(IDX_W), .VIDEO_IDX(VIDEO_IDX)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_active (cfg_active),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_data   (map_entry_t'(cfg_data)),
        .rd_idx     (addr[ADDR_W-1:IDX_LSB]),
        .rd_entry   (entry)
    );

    mmd_cycle_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .phi2        (phi2),
        .phi2_rise   (phi2_rise),
        .cfg_active  (cfg_active),
        .entry       (entry),
        .rw          (rw),
        .ram_sel     (ram_sel),
        .rom_sel     (rom_sel),
        .ram_wr      (ram_wr),
        .xcvr_en     (xcvr_en),
        .xcvr_to_cpu (xcvr_to_cpu)
    );
endmodule

// File: tb/memmap_decoder_bench.sv
module memmap_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] addr = '0;
    logic        rw = 1'b1;
    logic        cfg_active = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [3:0]  cfg_data = '0;
    logic ram_sel, rom_sel, ram_wr, xcvr_en, xcvr_to_cpu;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    memmap_decoder u_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .addr(addr), .rw(rw),
        .cfg_active(cfg_active), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .ram_sel(ram_sel), .rom_sel(rom_sel),
        .ram_wr(ram_wr), .xcvr_en(xcvr_en), .xcvr_to_cpu(xcvr_to_cpu)
    );

    // {addr, rw, expected {ram_sel, rom_sel, xcvr_en, xcvr_to_cpu, ram_wr}}
    localparam logic [21:0] VEC [12] = '{
        {16'h0100, 1'b1, 5'b10000},   // R1 R2 RAM read
        {16'h0100, 1'b0, 5'b10001},   // R5 RAM write strobe
        {16'h0900, 1'b0, 5'b10000},   // R4 protected write
        {16'h0900, 1'b1, 5'b10000},   // R4 protected read
        {16'hA000, 1'b1, 5'b01000},   // R2 ROM read
        {16'hA000, 1'b0, 5'b01000},   // R5 no strobe on ROM
        {16'hE810, 1'b1, 5'b00110},   // R6 I/O read toward CPU
        {16'hE810, 1'b0, 5'b00100},   // R6 I/O write toward board
        {16'hE000, 1'b1, 5'b00000},   // R1 neighbour window empty
        {16'h8000, 1'b1, 5'b00110},   // R7 video read
        {16'h8000, 1'b0, 5'b00100},   // R7 video write, no RAM
        {16'hF800, 1'b1, 5'b00000}    // R1 unused window
    };

    function automatic logic [4:0] outs();
        return {ram_sel, rom_sel, xcvr_en, xcvr_to_cpu, ram_wr};
    endfunction

    task automatic check(string req, logic [4:0] got, logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b expected %b", req, got, exp);
        end
    endtask

    task automatic load(logic [4:0] idx, logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Raise phi2 with addr/rw, sample after the capture edge.
    task automatic start_cycle(logic [15:0] a, logic r);
        @(negedge clk);
        addr = a; rw = r; phi2 = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic end_cycle();
        @(negedge clk);
        phi2 = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        check("R9 outputs in reset", outs(), 5'b00000);
        @(negedge clk); rst_n = 1'b1;
        // R9: cleared table selects nothing
        start_cycle(16'h0100, 1'b1);
        check("R9 empty table", outs(), 5'b00000);
        end_cycle();
        // R8: write outside configuration is ignored
        load(5'd0, 4'b1000);
        start_cycle(16'h0100, 1'b1);
        check("R8 write ignored", outs(), 5'b00000);
        end_cycle();
        // load configuration
        @(negedge clk); cfg_active = 1'b1;
        load(5'd0, 4'b1000);
        load(5'd1, 4'b1001);
        load(5'd20, 4'b0100);
        load(5'd29, 4'b0010);
        load(5'd16, 4'b1000);
        @(negedge clk); cfg_active = 1'b0;
        for (int i = 0; i < 12; i++) begin
            start_cycle(VEC[i][21:6], VEC[i][5]);
            check("R1-table vector", outs(), VEC[i][4:0]);
            end_cycle();
            check("R3 drop on phi2 low", outs(), 5'b00000);
        end
        // R3: address moves while phi2 high, decode held
        start_cycle(16'h0100, 1'b0);
        @(negedge clk); addr = 16'hA000; rw = 1'b1;
        @(posedge clk); #1;
        check("R3 hold during phi2", outs(), 5'b10001);
        end_cycle();
        // R8: phase-2 rise during configuration write -> quiet, write wins
        @(negedge clk);
        cfg_active = 1'b1; cfg_we = 1'b1; cfg_idx = 5'd2; cfg_data = 4'b0100;
        addr = 16'h0100; rw = 1'b1; phi2 = 1'b1;
        @(posedge clk); #1;
        check("R8 quiet in config", outs(), 5'b00000);
        @(negedge clk); cfg_we = 1'b0; cfg_active = 1'b0; phi2 = 1'b0;
        start_cycle(16'h1000, 1'b1);
        check("R8 config write took", outs(), 5'b01000);
        end_cycle();
        // R9: reset clears a loaded table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        start_cycle(16'h0100, 1'b0);
        check("R9 table cleared", outs(), 5'b00000);
        end_cycle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule